// File: doc/BRIEF.md
# Multi-Drop Bus Slave Frame Handler

This block is the frame layer of one slave node on a half-duplex, single-master, multi-drop serial bus. Bytes arrive from a UART receiver over a valid/ready stream. The block hunts for a start byte and parses a small framed packet. It acts only on frames that carry its own node address or the broadcast address, and only when the checksum is correct. A slave never speaks first. When a frame is addressed to this node alone, the block builds a six-byte reply and raises the bus-direction output around it. The reply goes out through a byte stream to a UART transmitter.

The master moves the node between three modes with control frames: query, upgrade and finished. In upgrade mode the payload of a data frame is held in a local buffer until the checksum byte has been checked. Only then is the payload handed, in order, to a downstream write port that feeds configuration storage. After the upgrade ends, the node waits in the finished mode until the master says either restart, which raises a one-cycle request, or resume.

Frame layout on the wire: 0x7E, address, type, length N, N payload bytes, checksum. Type 0x01 is control, 0x02 is reply and 0x03 is data.

Top module: `bus_slave_frame_handler`

## Requirements
- R1: While hunting, every byte other than 0x7E is ignored. A frame is accepted only when the 8-bit sum of address, type, length, payload and checksum bytes is 0x00.
- R2: A frame whose address is neither NODE_ID nor 0xFF causes no reply, no write and no mode change.
- R3: A frame with a wrong checksum is dropped silently: no reply, no write, no mode change.
- R4: A reply is exactly 0x7E, NODE_ID, 0x02, 0x01, status, checksum. The checksum makes the sum of the last five bytes 0x00. Status bit 7 is the reject flag, bits 6..2 are zero, and bits 1..0 are the mode after the frame was applied. txData is held stable while txValid waits for txReady.
- R5: A frame sent to 0xFF is acted on like one sent to NODE_ID, but no reply is sent.
- R6: Modes are encoded as nodeMode: 0 query, 1 upgrade, 2 finished. Reset enters query. Command 0x10 in payload byte 0 selects query and command 0x20 selects upgrade; both are accepted in any mode.
- R7: Command 0x30 moves upgrade to finished. Command 0x40 in finished mode pulses restartReq for one cycle and returns to query. Command 0x41 in finished mode returns to query. In any other mode these three commands are rejected and leave the mode unchanged, as are unknown commands and control frames with zero length.
- R8: In upgrade mode, a data frame's payload appears on the write port in order, one byte per wrValid/wrReady handshake. No byte appears before the checksum byte has been accepted. The reply is sent after the last write and has status bit 7 clear.
- R9: A data frame outside upgrade mode writes nothing and is answered with status bit 7 set.
- R10: Payloads up to BUF_DEPTH bytes are accepted. A frame with a longer length field is dropped silently.
- R11: dirTx is high for exactly BIT_CYCLES cycles before the first txValid of a reply. It stays high until txIdle reports the transmitter empty after the last byte, and it is low at all other times.
- R12: Mid-frame, if no byte is accepted for more than gapLimit consecutive cycles, the partial frame is discarded and the parser hunts again. Shorter gaps are tolerated.
- R13: Frames of any type other than 0x01 and 0x03, including replies from other slaves, are ignored.
- R14: rxReady is low while a frame is being carried out or a reply is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gapLimit | input | GAP_W | Largest tolerated idle gap between bytes of a frame, in cycles |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte valid |
| rxReady | output | 1 | Block accepts a received byte |
| txData | output | 8 | Reply byte to transmitter |
| txValid | output | 1 | Reply byte valid |
| txReady | input | 1 | Transmitter takes the byte |
| txIdle | input | 1 | Transmitter has shifted out its last stop bit |
| wrData | output | 8 | Verified payload byte to storage |
| wrValid | output | 1 | Payload byte valid |
| wrReady | input | 1 | Storage takes the byte |
| dirTx | output | 1 | Bus direction: 1 drive, 0 listen |
| nodeMode | output | 2 | Current mode (0 query, 1 upgrade, 2 finished) |
| restartReq | output | 1 | One-cycle restart request |

## Verification
The parser is driven with clean frames, leading junk bytes, a corrupted checksum, a foreign address, the broadcast address and a foreign frame type. These patterns separate acceptance by address from acceptance by integrity and from acceptance by type. Data frames of 3, 16 and 17 bytes sit on both sides of the buffer limit, and a stalling write port checks that ordering and holding survive backpressure. Inter-byte gaps just below and well above the timeout separate a tolerated pause from an abandoned frame. The full command walk through all three modes, including rejected commands in the wrong mode, tells legal transitions from illegal ones.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam logic [7:0] SOF_BYTE   = 8'h7E;
  localparam logic [7:0] BCAST_ADDR = 8'hFF;
  localparam logic [7:0] T_CTRL     = 8'h01;
  localparam logic [7:0] T_RESP     = 8'h02;
  localparam logic [7:0] T_DATA     = 8'h03;
  localparam logic [7:0] C_QUERY    = 8'h10;
  localparam logic [7:0] C_UPGRADE  = 8'h20;
  localparam logic [7:0] C_FINISH   = 8'h30;
  localparam logic [7:0] C_RESTART  = 8'h40;
  localparam logic [7:0] C_RESUME   = 8'h41;
  localparam int         RESP_LEN   = 6;

  typedef enum logic [1:0] {
    MODE_QUERY   = 2'd0,
    MODE_UPGRADE = 2'd1,
    MODE_DONE    = 2'd2
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic capAddr;
    logic capType;
    logic capLen;
    logic capPay;
    logic addSum;
    logic rstIdx;
    logic incIdx;
    logic gapClr;
  } strobeT;
endpackage

// File: rtl/bsf_datapath.sv
module bsf_datapath
  import bsf_pkg::*;
#(
  parameter logic [7:0] NODE_ID   = 8'h05,
  parameter int         BUF_DEPTH = 16,
  parameter int         GAP_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [7:0]       rxData,
  input  logic [GAP_W-1:0] gapLimit,
  input  logic [7:0]       respStatus,
  output logic             rxIsSof,
  output logic             rxIsZero,
  output logic             payLast,
  output logic             respLast,
  output logic             sumZero,
  output logic             addrOk,
  output logic             addrBcast,
  output logic             lenTooBig,
  output logic             lenZero,
  output logic             gapHit,
  output logic [7:0]       typeReg,
  output logic [7:0]       cmdByte,
  output logic [7:0]       wrData,
  output logic [7:0]       txData
);
  localparam int         AW     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [8:0] DEPTH9 = 9'(BUF_DEPTH);

  logic [7:0]       addrReg;
  logic [7:0]       lenReg;
  logic [7:0]       sumReg;
  logic [7:0]       idx;
  logic [GAP_W-1:0] gapCnt;
  logic [7:0]       payBuf [BUF_DEPTH];
  logic [7:0]       respCks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      typeReg <= '0;
      lenReg  <= '0;
      sumReg  <= '0;
      idx     <= '0;
      gapCnt  <= '0;
    end else begin
      if (stb.clrFrame)    sumReg <= '0;
      else if (stb.addSum) sumReg <= sumReg + rxData;
      if (stb.capAddr) addrReg <= rxData;
      if (stb.capType) typeReg <= rxData;
      if (stb.capLen)  lenReg  <= rxData;
      if (stb.rstIdx)      idx <= '0;
      else if (stb.incIdx) idx <= idx + 8'd1;
      if (stb.gapClr)      gapCnt <= '0;
      else if (!gapHit)    gapCnt <= gapCnt + 1'b1;
    end
  end

  // payload bytes beyond the buffer are not stored; the frame is dropped later
  always_ff @(posedge clk) begin
    if (stb.capPay && ({1'b0, idx} < DEPTH9)) payBuf[idx[AW-1:0]] <= rxData;
  end

  assign rxIsSof   = (rxData == SOF_BYTE);
  assign rxIsZero  = (rxData == 8'd0);
  assign payLast   = (idx == lenReg - 8'd1);
  assign respLast  = (idx == 8'(RESP_LEN - 1));
  assign sumZero   = (sumReg == 8'd0);
  assign addrBcast = (addrReg == BCAST_ADDR);
  assign addrOk    = (addrReg == NODE_ID) || addrBcast;
  assign lenTooBig = ({1'b0, lenReg} > DEPTH9);
  assign lenZero   = (lenReg == 8'd0);
  assign gapHit    = (gapCnt >= gapLimit);
  assign cmdByte   = payBuf[0];
  assign wrData    = payBuf[idx[AW-1:0]];
  assign respCks   = 8'h00 - (NODE_ID + T_RESP + 8'h01 + respStatus);

  always_comb begin
    case (idx)
      8'd0:    txData = SOF_BYTE;
      8'd1:    txData = NODE_ID;
      8'd2:    txData = T_RESP;
      8'd3:    txData = 8'h01;
      8'd4:    txData = respStatus;
      default: txData = respCks;
    endcase
  end
endmodule

// File: rtl/bsf_control.sv
module bsf_control
  import bsf_pkg::*;
#(
  parameter int BIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  output logic       rxReady,
  output logic       txValid,
  input  logic       txReady,
  input  logic       txIdle,
  output logic       wrValid,
  input  logic       wrReady,
  output logic       dirTx,
  output logic [1:0] nodeMode,
  output logic       restartReq,
  output logic [7:0] respStatus,
  output strobeT     stb,
  input  logic       rxIsSof,
  input  logic       rxIsZero,
  input  logic       payLast,
  input  logic       respLast,
  input  logic       sumZero,
  input  logic       addrOk,
  input  logic       addrBcast,
  input  logic       lenTooBig,
  input  logic       lenZero,
  input  logic       gapHit,
  input  logic [7:0] typeReg,
  input  logic [7:0] cmdByte
);
  localparam int LEAD_W = $clog2(BIT_CYCLES + 1);

  typedef enum logic [3:0] {
    S_HUNT, S_ADDR, S_TYPE, S_LEN, S_PAY, S_CKS,
    S_EXEC, S_FWD, S_LEAD, S_SEND, S_DRAIN
  } stateT;

  stateT             state, stateNxt;
  modeT              mode, modeNxt;
  logic [7:0]        statusNxt;
  logic              restartNxt;
  logic              nak;
  logic              inFrame;
  logic              rxFire;
  logic              frameOk;
  logic [LEAD_W-1:0] leadCnt;
  stateT             replyOrHunt;

  assign inFrame     = (state == S_ADDR) || (state == S_TYPE) || (state == S_LEN) ||
                       (state == S_PAY)  || (state == S_CKS);
  assign rxReady     = (state == S_HUNT) || inFrame;
  assign rxFire      = rxValid && rxReady;
  assign dirTx       = (state == S_LEAD) || (state == S_SEND) || (state == S_DRAIN);
  assign nodeMode    = mode;
  assign frameOk     = sumZero && addrOk && !lenTooBig &&
                       ((typeReg == T_CTRL) || (typeReg == T_DATA));
  assign replyOrHunt = addrBcast ? S_HUNT : S_LEAD;

  always_comb begin
    stateNxt    = state;
    modeNxt     = mode;
    statusNxt   = respStatus;
    restartNxt  = 1'b0;
    nak         = 1'b1;
    stb         = '0;
    stb.gapClr  = !inFrame || rxFire;
    txValid     = 1'b0;
    wrValid     = 1'b0;
    case (state)
      S_HUNT: if (rxFire && rxIsSof) begin
        stb.clrFrame = 1'b1;
        stateNxt     = S_ADDR;
      end
      S_ADDR: if (rxFire) begin
        stb.capAddr = 1'b1; stb.addSum = 1'b1; stateNxt = S_TYPE;
      end else if (gapHit) stateNxt = S_HUNT;
      S_TYPE: if (rxFire) begin
        stb.capType = 1'b1; stb.addSum = 1'b1; stateNxt = S_LEN;
      end else if (gapHit) stateNxt = S_HUNT;
      S_LEN: if (rxFire) begin
        stb.capLen = 1'b1; stb.addSum = 1'b1; stb.rstIdx = 1'b1;
        stateNxt   = rxIsZero ? S_CKS : S_PAY;
      end else if (gapHit) stateNxt = S_HUNT;
      S_PAY: if (rxFire) begin
        stb.capPay = 1'b1; stb.addSum = 1'b1; stb.incIdx = 1'b1;
        if (payLast) stateNxt = S_CKS;
      end else if (gapHit) stateNxt = S_HUNT;
      S_CKS: if (rxFire) begin
        stb.addSum = 1'b1; stateNxt = S_EXEC;
      end else if (gapHit) stateNxt = S_HUNT;
      S_EXEC: begin
        stb.rstIdx = 1'b1;
        if (!frameOk) begin
          stateNxt = S_HUNT;
        end else if (typeReg == T_CTRL) begin
          if (!lenZero) begin
            case (cmdByte)
              C_QUERY:   begin nak = 1'b0; modeNxt = MODE_QUERY; end
              C_UPGRADE: begin nak = 1'b0; modeNxt = MODE_UPGRADE; end
              C_FINISH:  if (mode == MODE_UPGRADE) begin
                nak = 1'b0; modeNxt = MODE_DONE;
              end
              C_RESTART: if (mode == MODE_DONE) begin
                nak = 1'b0; modeNxt = MODE_QUERY; restartNxt = 1'b1;
              end
              C_RESUME:  if (mode == MODE_DONE) begin
                nak = 1'b0; modeNxt = MODE_QUERY;
              end
              default:   nak = 1'b1;
            endcase
          end
          statusNxt = {nak, 5'b0, modeNxt};
          stateNxt  = replyOrHunt;
        end else begin
          nak       = (mode != MODE_UPGRADE);
          statusNxt = {nak, 5'b0, mode};
          stateNxt  = (nak || lenZero) ? replyOrHunt : S_FWD;
        end
      end
      S_FWD: begin
        wrValid = 1'b1;
        if (wrReady) begin
          if (payLast) begin
            stb.rstIdx = 1'b1;
            stateNxt   = replyOrHunt;
          end else begin
            stb.incIdx = 1'b1;
          end
        end
      end
      S_LEAD: if (leadCnt == LEAD_W'(BIT_CYCLES - 1)) stateNxt = S_SEND;
      S_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          stb.incIdx = 1'b1;
          if (respLast) stateNxt = S_DRAIN;
        end
      end
      S_DRAIN: if (txIdle) stateNxt = S_HUNT;
      default: stateNxt = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_HUNT;
      mode       <= MODE_QUERY;
      respStatus <= '0;
      restartReq <= 1'b0;
      leadCnt    <= '0;
    end else begin
      state      <= stateNxt;
      mode       <= modeNxt;
      respStatus <= statusNxt;
      restartReq <= restartNxt;
      leadCnt    <= (state == S_LEAD) ? leadCnt + 1'b1 : '0;
    end
  end

  p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);
  p_wr_verified_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> sumZero && addrOk);
  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    nodeMode != 2'd3);
  p_rx_blocked_r14: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || txValid) |-> !rxReady);
endmodule

// File: rtl/bus_slave_frame_handler.sv
module bus_slave_frame_handler
  import bsf_pkg::*;
#(
  parameter logic [7:0] NODE_ID    = 8'h05,
  parameter int         BUF_DEPTH  = 16,
  parameter int         BIT_CYCLES = 8,
  parameter int         GAP_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GAP_W-1:0] gapLimit,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  output logic             rxReady,
  output logic [7:0]       txData,
  output logic             txValid,
  input  logic             txReady,
  input  logic             txIdle,
  output logic [7:0]       wrData,
  output logic             wrValid,
  input  logic             wrReady,
  output logic             dirTx,
  output logic [1:0]       nodeMode,
  output logic             restartReq
);
  strobeT     stb;
  logic [7:0] respStatus, typeReg, cmdByte;
  logic       rxIsSof, rxIsZero, payLast, respLast, sumZero;
  logic       addrOk, addrBcast, lenTooBig, lenZero, gapHit;

  bsf_control #(.BIT_CYCLES(BIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxReady(rxReady),
    .txValid(txValid), .txReady(txReady), .txIdle(txIdle),
    .wrValid(wrValid), .wrReady(wrReady), .dirTx(dirTx),
    .nodeMode(nodeMode), .restartReq(restartReq), .respStatus(respStatus),
    .stb(stb), .rxIsSof(rxIsSof), .rxIsZero(rxIsZero), .payLast(payLast),
    .respLast(respLast), .sumZero(sumZero), .addrOk(addrOk),
    .addrBcast(addrBcast), .lenTooBig(lenTooBig), .lenZero(lenZero),
    .gapHit(gapHit), .typeReg(typeReg), .cmdByte(cmdByte)
  );

  bsf_datapath #(.NODE_ID(NODE_ID), .BUF_DEPTH(BUF_DEPTH), .GAP_W(GAP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxData(rxData), .gapLimit(gapLimit),
    .respStatus(respStatus), .rxIsSof(rxIsSof), .rxIsZero(rxIsZero),
    .payLast(payLast), .respLast(respLast), .sumZero(sumZero),
    .addrOk(addrOk), .addrBcast(addrBcast), .lenTooBig(lenTooBig),
    .lenZero(lenZero), .gapHit(gapHit), .typeReg(typeReg),
    .cmdByte(cmdByte), .wrData(wrData), .txData(txData)
  );

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrData));
  p_dir_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirTx) |-> $past(txIdle));
endmodule

// File: tb/bus_slave_frame_handler_tb.sv
module bus_slave_frame_handler_tb;
  localparam logic [7:0] NODE = 8'h05;
  localparam int DEPTH = 16;
  localparam int BITC  = 8;
  localparam int TXB   = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] gapLimit = 16'd20;
  logic [7:0]  rxData = 8'h00;
  logic        rxValid = 1'b0;
  logic        rxReady, txValid, txReady, txIdle, wrValid, wrReady, dirTx, restartReq;
  logic [7:0]  txData, wrData;
  logic [1:0]  nodeMode;

  int tests = 0, fails = 0;
  int txCount = 0, wrCount = 0, restartSeen = 0;
  int leadCnt = 0, rxViol = 0, dirViol = 0;
  bit sentAny = 0, prevDir = 0, finished = 0;
  logic [7:0] txExp[$], wrExp[$], pl[$];
  logic [5:0] uBusy;
  logic [1:0] wrTick;

  always #4 clk = ~clk;

  bus_slave_frame_handler #(.NODE_ID(NODE), .BUF_DEPTH(DEPTH), .BIT_CYCLES(BITC), .GAP_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .gapLimit(gapLimit), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txIdle(txIdle), .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .dirTx(dirTx), .nodeMode(nodeMode), .restartReq(restartReq)
  );

  // transmitter model: one byte in flight, TXB cycles per byte
  assign txIdle  = (uBusy == 0);
  assign txReady = (uBusy == 0);
  assign wrReady = (wrTick != 2'b11);
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin uBusy <= '0; wrTick <= '0; end
    else begin
      wrTick <= wrTick + 2'd1;
      if (txValid && txReady) uBusy <= 6'(TXB);
      else if (uBusy != 0)    uBusy <= uBusy - 6'd1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (txValid && txReady) begin
        txCount++;
        if (txExp.size() == 0) check(0, "R4 unexpected reply byte", txData, 0);
        else begin
          automatic logic [7:0] e = txExp.pop_front();
          check(txData == e, "R4 reply byte", txData, e);
        end
      end
      if (wrValid && wrReady) begin
        wrCount++;
        if (wrExp.size() == 0) check(0, "R8 unexpected write", wrData, 0);
        else begin
          automatic logic [7:0] e = wrExp.pop_front();
          check(wrData == e, "R8 write byte", wrData, e);
        end
      end
      if (restartReq) restartSeen++;
      if (dirTx && !txValid && !sentAny) leadCnt++;
      if (txValid && !sentAny) begin
        check(leadCnt == BITC, "R11 lead time", leadCnt, BITC);
        sentAny = 1;
      end
      if (prevDir && !dirTx) begin
        check(txIdle == 1'b1, "R11 release after idle", txIdle, 1);
        sentAny = 0;
        leadCnt = 0;
      end
      if (dirTx && rxReady) rxViol++;
      if (!dirTx && !txIdle) dirViol++;
      prevDir = dirTx;
    end
  end

  task automatic sendByte(input logic [7:0] b, input int gap);
    @(negedge clk);
    rxData = b; rxValid = 1'b1;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // sends frame with payload in pl; cksAdj corrupts the checksum
  task automatic sendFrame(input logic [7:0] addr, input logic [7:0] typ, input logic [7:0] cksAdj, input int gap);
    logic [7:0] s;
    s = addr + typ + 8'(pl.size());
    sendByte(8'h7E, gap); sendByte(addr, gap); sendByte(typ, gap); sendByte(8'(pl.size()), gap);
    foreach (pl[i]) begin sendByte(pl[i], gap); s = s + pl[i]; end
    sendByte(8'h00 - s + cksAdj, 0);
  endtask

  task automatic expReply(input logic [7:0] st);
    txExp.push_back(8'h7E); txExp.push_back(NODE); txExp.push_back(8'h02);
    txExp.push_back(8'h01); txExp.push_back(st);
    txExp.push_back(8'h00 - (NODE + 8'h02 + 8'h01 + st));
  endtask

  task automatic expPayload();
    foreach (pl[i]) wrExp.push_back(pl[i]);
  endtask

  task automatic waitQuiet();
    repeat (12) @(negedge clk);
    while (dirTx || txExp.size() != 0 || wrExp.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic ctrl(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] st, input bit reply);
    pl = {cmd};
    sendFrame(addr, 8'h01, 8'h00, 2);
    if (reply) expReply(st);
    waitQuiet();
  endtask

  task automatic fillPl(input int n, input logic [7:0] seed);
    pl = {};
    for (int i = 0; i < n; i++) pl.push_back(seed + 8'(i * 7));
  endtask

  initial begin
    int t0, w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(nodeMode == 2'd0, "R6 reset mode", nodeMode, 0);
    check(dirTx == 1'b0, "R11 reset dir", dirTx, 0);
    check(!txValid && !wrValid, "R8 reset outputs", {txValid, wrValid}, 0);
    check(rxReady == 1'b1, "R14 reset rxReady", rxReady, 1);

    // R1: junk before start byte, then query command
    sendByte(8'h11, 1); sendByte(8'h22, 1);
    ctrl(NODE, 8'h10, 8'h00, 1);
    check(nodeMode == 2'd0, "R1 query mode", nodeMode, 0);

    // R6: enter upgrade
    ctrl(NODE, 8'h20, 8'h01, 1);
    check(nodeMode == 2'd1, "R6 upgrade mode", nodeMode, 1);

    // R8: data frames, small and at buffer limit (R10)
    fillPl(3, 8'h31); sendFrame(NODE, 8'h03, 8'h00, 2); expPayload(); expReply(8'h01); waitQuiet();
    fillPl(DEPTH, 8'h90); sendFrame(NODE, 8'h03, 8'h00, 1); expPayload(); expReply(8'h01); waitQuiet();
    check(wrCount == 3 + DEPTH, "R8 write count", wrCount, 3 + DEPTH);

    // R10: over-long payload dropped
    t0 = txCount; w0 = wrCount;
    fillPl(DEPTH + 1, 8'h05); sendFrame(NODE, 8'h03, 8'h00, 1); waitQuiet();
    check(txCount == t0 && wrCount == w0, "R10 long frame dropped", txCount - t0 + wrCount - w0, 0);

    // R3: bad checksum
    fillPl(4, 8'h44); sendFrame(NODE, 8'h03, 8'h01, 1); waitQuiet();
    check(txCount == t0 && wrCount == w0, "R3 bad checksum dropped", txCount - t0 + wrCount - w0, 0);

    // R2: foreign address, even a mode command
    ctrl(8'h09, 8'h10, 8'h00, 0);
    check(txCount == t0 && nodeMode == 2'd1, "R2 foreign address ignored", nodeMode, 1);

    // R5: broadcast data is written but not answered
    fillPl(2, 8'hA0); sendFrame(8'hFF, 8'h03, 8'h00, 2); expPayload(); waitQuiet();
    check(txCount == t0 && wrCount == w0 + 2, "R5 broadcast no reply", txCount - t0, 0);

    // R13: foreign frame type
    pl = {8'h10}; sendFrame(NODE, 8'h02, 8'h00, 2); waitQuiet();
    check(txCount == t0 && nodeMode == 2'd1, "R13 reply type ignored", txCount - t0, 0);

    // R12: gap beyond limit discards, gap inside limit kept
    sendByte(8'h7E, 1); sendByte(NODE, 50);
    sendByte(8'h01, 1); sendByte(8'h01, 1); sendByte(8'h10, 1); sendByte(8'hE9, 0);
    waitQuiet();
    check(txCount == t0 && nodeMode == 2'd1, "R12 stale frame discarded", nodeMode, 1);
    pl = {8'h20}; sendFrame(NODE, 8'h01, 8'h00, 15); expReply(8'h01); waitQuiet();
    check(txCount == t0 + 6, "R12 short gaps tolerated", txCount - t0, 6);

    // R8: zero-length data frame in upgrade mode
    pl = {}; sendFrame(NODE, 8'h03, 8'h00, 2); expReply(8'h01); waitQuiet();

    // R7: finish, then R9 data rejected while finished
    ctrl(NODE, 8'h30, 8'h02, 1);
    check(nodeMode == 2'd2, "R7 finished mode", nodeMode, 2);
    w0 = wrCount;
    fillPl(3, 8'h11); sendFrame(NODE, 8'h03, 8'h00, 2); expReply(8'h82); waitQuiet();
    check(wrCount == w0, "R9 no write outside upgrade", wrCount - w0, 0);
    ctrl(NODE, 8'h30, 8'h82, 1);
    ctrl(NODE, 8'h41, 8'h00, 1);
    check(nodeMode == 2'd0, "R7 resume to query", nodeMode, 0);
    ctrl(NODE, 8'h40, 8'h80, 1);
    check(restartSeen == 0, "R7 restart rejected in query", restartSeen, 0);
    ctrl(NODE, 8'h20, 8'h01, 1);
    ctrl(NODE, 8'h30, 8'h02, 1);
    ctrl(NODE, 8'h40, 8'h00, 1);
    check(restartSeen == 1, "R7 restart pulse", restartSeen, 1);
    check(nodeMode == 2'd0, "R7 restart to query", nodeMode, 0);

    // R7: unknown command and empty control frame
    ctrl(NODE, 8'h77, 8'h80, 1);
    pl = {}; sendFrame(NODE, 8'h01, 8'h00, 2); expReply(8'h80); waitQuiet();

    // R5: broadcast command changes mode silently
    t0 = txCount;
    ctrl(8'hFF, 8'h20, 8'h00, 0);
    check(nodeMode == 2'd1 && txCount == t0, "R5 broadcast command", nodeMode, 1);

    check(rxViol == 0, "R14 rx blocked while driving", rxViol, 0);
    check(dirViol == 0, "R11 dir low only when idle", dirViol, 0);
    check(txExp.size() == 0 && wrExp.size() == 0, "R4 all expected seen", txExp.size() + wrExp.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule